// File: doc/BRIEF.md
# Precharge and Evaluate Cycle Sequencer

This block drives the control lines of a dynamic-logic processing array that needs a precharge before each computation. All timing is counted in ticks of the 20 ns system clock. After a trigger, each cycle runs through the same steps. First comes one tick with every control line at rest. Precharge is then held high for four ticks. A fixed settling gap of eight ticks follows. The active-low start line then drops for four ticks, which is the evaluate phase. The cycle ends with a programmable tail of wait states.

The tail length comes from an 8-bit count. A count of N gives N+1 wait states, so a cycle lasts between 18 ticks (360 ns) and 273 ticks (5.46 us). The count is captured only as a cycle begins. In single-shot mode the sequencer returns to rest after one cycle. While rest lasts, the discharge line is held high to limit leakage. In repeating mode a new cycle starts on the tick right after the previous one ends. Each cycle ends with a one-tick done strobe.

Top module: `precharge_cycle_seq`

## Requirements
- R1: While reset is asserted and after it is released with no trigger, precharge is low, start (active low) is high, discharge is high and done is low.
- R2: A trigger seen at rest starts a cycle on the next clock edge. The first tick of a cycle keeps the rest levels: precharge 0, start 1, discharge 1, done 0.
- R3: Ticks 1 to 4 of a cycle have precharge high, start high and discharge low.
- R4: Ticks 5 to 12 (the settling gap) have precharge low, start high and discharge low. Start falls exactly eight ticks after precharge has fallen.
- R5: Ticks 13 to 16 have start low, precharge low and discharge low.
- R6: With a wait count N (0 to 255), ticks 17 to 17+N are wait states with precharge low, start high and discharge low. The cycle therefore lasts N+18 ticks.
- R7: Done is high for exactly one tick, the last wait state of each cycle, and is low at all other times.
- R8: The wait count is captured on the edge that starts a cycle. Changes made to it later in that cycle do not change that cycle's length.
- R9: In single-shot mode (continuous low on the last tick), the tick after the cycle returns to rest levels, and they hold until the next trigger.
- R10: In repeating mode (continuous high on the last tick), the tick after the cycle is tick 0 of a new cycle.
- R11: A trigger during a running cycle is ignored. The cycle keeps its length and phase timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Trigger for a cycle, sampled at rest |
| continuous | input | 1 | Repeat cycles back to back when high |
| waitCount | input | 8 | Wait states minus one |
| prechargeOut | output | 1 | Precharge control, active high |
| startN | output | 1 | Evaluate start, active low |
| dischargeOut | output | 1 | Leakage-limiting discharge, high at rest |
| cycleDone | output | 1 | One-tick strobe on the last tick of a cycle |

## Verification
The bench goes after both ends of the tail, a count of 0 and a count of 255. An off-by-one in the wait decode shows up there as a cycle of 17 or 19 ticks, or as a wrap to a single wait state. It also changes the wait count and pulses the trigger in the middle of cycles. A design that read the count continuously, or that restarted on a late trigger, would stretch or cut short the cycle under test. Repeating runs with a different count in each cycle check that there is no idle tick between cycles and that the done strobe sits on the last tick only. A precharge or gap counter that is one tick off moves the start edge, and the per-tick comparison catches that.

// File: rtl/cycle_seq_pkg.sv
package cycle_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_PRE  = 3'd2,
    ST_GAP  = 3'd3,
    ST_EVAL = 3'd4,
    ST_WAIT = 3'd5
  } seqState_e;

  // Strobes from control to the tick datapath
  typedef struct packed {
    logic      restart;   // phase changes on this edge: clear tick counter
    logic      loadWait;  // a new cycle begins: capture the wait count
    seqState_e phase;     // phase currently running
  } seqStrobe_t;

endpackage

// File: rtl/cycle_seq_dp.sv
module cycle_seq_dp
  import cycle_seq_pkg::*;
#(
  parameter int PRE_TICKS  = 4,
  parameter int GAP_TICKS  = 8,
  parameter int EVAL_TICKS = 4,
  parameter int WAIT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [WAIT_W-1:0] waitCount,
  output logic              phaseLast
);

  localparam int CNT_W = WAIT_W + 1;

  logic [CNT_W-1:0]  tickCnt;
  logic [WAIT_W-1:0] waitReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.restart || strobe.phase == ST_IDLE) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitReg <= '0;
    end else if (strobe.loadWait) begin
      waitReg <= waitCount;
    end
  end

  always_comb begin
    unique case (strobe.phase)
      ST_INIT: phaseLast = (tickCnt == '0);
      ST_PRE:  phaseLast = (tickCnt == CNT_W'(PRE_TICKS - 1));
      ST_GAP:  phaseLast = (tickCnt == CNT_W'(GAP_TICKS - 1));
      ST_EVAL: phaseLast = (tickCnt == CNT_W'(EVAL_TICKS - 1));
      ST_WAIT: phaseLast = (tickCnt == {1'b0, waitReg});
      default: phaseLast = 1'b0;
    endcase
  end

endmodule

// File: rtl/cycle_seq_ctrl.sv
module cycle_seq_ctrl
  import cycle_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       go,
  input  logic       continuous,
  input  logic       phaseLast,
  output seqStrobe_t strobe,
  output logic       prechargeOut,
  output logic       startN,
  output logic       dischargeOut,
  output logic       cycleDone
);

  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (go)        nextState = ST_INIT;
      ST_INIT: if (phaseLast) nextState = ST_PRE;
      ST_PRE:  if (phaseLast) nextState = ST_GAP;
      ST_GAP:  if (phaseLast) nextState = ST_EVAL;
      ST_EVAL: if (phaseLast) nextState = ST_WAIT;
      ST_WAIT: if (phaseLast) nextState = continuous ? ST_INIT : ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.phase    = state;
    strobe.restart  = (nextState != state);
    strobe.loadWait = (nextState == ST_INIT) && (state != ST_INIT);
  end

  assign prechargeOut = (state == ST_PRE);
  assign startN       = (state != ST_EVAL);
  assign dischargeOut = (state == ST_IDLE) || (state == ST_INIT);
  assign cycleDone    = (state == ST_WAIT) && phaseLast;

endmodule

// File: rtl/precharge_cycle_seq.sv
module precharge_cycle_seq
  import cycle_seq_pkg::*;
#(
  parameter int PRE_TICKS  = 4,
  parameter int GAP_TICKS  = 8,
  parameter int EVAL_TICKS = 4,
  parameter int WAIT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic              continuous,
  input  logic [WAIT_W-1:0] waitCount,
  output logic              prechargeOut,
  output logic              startN,
  output logic              dischargeOut,
  output logic              cycleDone
);

  seqStrobe_t strobe;
  logic       phaseLast;

  cycle_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .go           (go),
    .continuous   (continuous),
    .phaseLast    (phaseLast),
    .strobe       (strobe),
    .prechargeOut (prechargeOut),
    .startN       (startN),
    .dischargeOut (dischargeOut),
    .cycleDone    (cycleDone)
  );

  cycle_seq_dp #(
    .PRE_TICKS  (PRE_TICKS),
    .GAP_TICKS  (GAP_TICKS),
    .EVAL_TICKS (EVAL_TICKS),
    .WAIT_W     (WAIT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .waitCount (waitCount),
    .phaseLast (phaseLast)
  );

endmodule

// File: rtl/cycle_seq_chk.sv
module cycle_seq_chk #(
  parameter int GAP_TICKS = 8
) (
  input logic clk,
  input logic rstN,
  input logic prechargeOut,
  input logic startN,
  input logic dischargeOut,
  input logic cycleDone
);

  // ticks elapsed since precharge was last high (saturating)
  logic [7:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lowRun <= 8'hFF;
    else if (prechargeOut) lowRun <= 8'd0;
    else if (lowRun != 8'hFF) lowRun <= lowRun + 8'd1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(prechargeOut && !startN)); // R5

  AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startN) |-> (lowRun == 8'(GAP_TICKS))); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone); // R7

  AST_REST_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> (dischargeOut && startN && !prechargeOut)); // R10

  AST_DISCHARGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    dischargeOut |-> (startN && !prechargeOut && !cycleDone)); // R9

endmodule

bind precharge_cycle_seq cycle_seq_chk #(.GAP_TICKS(GAP_TICKS)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .prechargeOut (prechargeOut),
  .startN       (startN),
  .dischargeOut (dischargeOut),
  .cycleDone    (cycleDone)
);

// File: tb/precharge_cycle_seq_tb.sv
module precharge_cycle_seq_tb;

  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       go = 1'b0;
  logic       continuous = 1'b0;
  logic [7:0] waitCount = 8'd0;
  logic       prechargeOut, startN, dischargeOut, cycleDone;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  precharge_cycle_seq u_dut (
    .clk(clk), .rstN(rstN), .go(go), .continuous(continuous),
    .waitCount(waitCount), .prechargeOut(prechargeOut), .startN(startN),
    .dischargeOut(dischargeOut), .cycleDone(cycleDone)
  );

  // expected {precharge, startN, discharge, done} at tick t of a cycle with w wait states
  function automatic logic [3:0] expTick(int t, int w);
    if (t == 0)        return 4'b0110;
    else if (t <= 4)   return 4'b1100;
    else if (t <= 12)  return 4'b0100;
    else if (t <= 16)  return 4'b0000;
    else if (t < 16 + w) return 4'b0100;
    else               return 4'b0101;
  endfunction

  function automatic string reqOf(int t, int w);
    if (t == 0)        return "R2";
    else if (t <= 4)   return "R3";
    else if (t <= 12)  return "R4";
    else if (t <= 16)  return "R5";
    else if (t < 16 + w) return "R6";
    else               return "R7";
  endfunction

  task automatic compare(string tag, logic [3:0] expVal);
    logic [3:0] act;
    act = {prechargeOut, startN, dischargeOut, cycleDone};
    checks++;
    if (act !== expVal) begin
      errors++;
      $display("FAIL %s: outputs {pre,startN,dis,done} actual=%b expected=%b at %0t",
               tag, act, expVal, $time);
    end
  endtask

  // Called at the negedge of tick 0; returns at the negedge following the cycle.
  task automatic runCycle(int w, logic [7:0] nextCount, bit pokeGo);
    for (int t = 0; t <= 16 + w; t++) begin
      compare(reqOf(t, w), expTick(t, w));
      if (t == 0) waitCount = 8'($urandom);       // R8: late change must not matter
      if (pokeGo && t == 6) go = 1'b1;            // R11: trigger while busy
      if (pokeGo && t == 9) go = 1'b0;
      if (t == 16 + w) waitCount = nextCount;
      @(negedge clk);
    end
  endtask

  task automatic singleShot(logic [7:0] cnt, bit pokeGo);
    waitCount = cnt;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    runCycle(int'(cnt) + 1, 8'($urandom), pokeGo);
    compare("R9", 4'b0110);
    @(negedge clk);
    compare("R9", 4'b0110);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] cnts [6];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare("R1", 4'b0110);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1", 4'b0110);

    // R6 minimum and maximum tails, R11 trigger mid-cycle
    singleShot(8'd0, 1'b0);
    singleShot(8'd255, 1'b1);
    singleShot(8'd1, 1'b1);

    // random single shots
    for (int i = 0; i < 6; i++) begin
      repeat (int'($urandom_range(0, 3))) @(negedge clk);
      singleShot(8'($urandom), i[0]);
    end

    // R10 repeating mode with a fresh count for each cycle
    cnts[0] = 8'd0; cnts[1] = 8'd255;
    for (int i = 2; i < 6; i++) cnts[i] = 8'($urandom);
    continuous = 1'b1;
    waitCount = cnts[0];
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i == 5) continuous = 1'b0;
      runCycle(int'(cnts[i]) + 1, (i < 5) ? cnts[i+1] : 8'd7, i == 3);
    end
    compare("R9", 4'b0110);
    repeat (4) @(negedge clk);
    compare("R9", 4'b0110);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule